// File: doc/BRIEF.md
# Fixed-Point Multiply Unit

This block is a pipelined 24-by-24-bit multiplier. One product core feeds several output formats. A 3-bit operation code picks the format for each operation: the low 32 bits of the integer product (unsigned or signed), a fixed-point result with 22 fraction bits, a fixed-point result with 16 fraction bits, or the whole product split over two 32-bit words.

Both operands arrive as 32-bit words, and only their low 24 bits take part. An operation is issued by raising the start strobe together with the operands and the code. The unit accepts one operation every cycle. Each result appears exactly two cycles later, qualified by a done strobe.

For the 22-fraction-bit modes, a request flag can send the result to a private accumulator-style result register instead of the destination outputs. In that case the destination outputs hold their previous value, and the destination write strobe stays low.

Top module: `fxmul_unit`

## Requirements
- R1: While reset is held low and in the first cycle after it, `doneOut`, `dstWrite`, `resLo`, `resHi` and `accOut` are all zero.
- R2: Operation code 0 (unsigned low) returns bits 31:0 of the unsigned 48-bit product on `resLo`. This covers splits such as 16x16, 12x20 and 8x24.
- R3: Operation code 1 (signed low) returns bits 31:0 of the two's-complement product on `resLo`.
- R4: Operation code 2 returns the signed product shifted right arithmetically by 22. Operation code 3 returns the unsigned product shifted right by 22. In both cases the result is bits 31:0 of the shifted value.
- R5: Operation code 6 returns the signed product shifted right arithmetically by 16, which is the 16.16 result of two 8.16 operands. Operation code 7 does the same shift on the unsigned product.
- R6: Operation codes 4 (unsigned) and 5 (signed) take the product extended to 64 bits. Zero extension is used for code 4 and sign extension for code 5. `resLo` carries bits 31:0 (the first word) and `resHi` carries bits 63:32 (the second word). Every other operation that writes the destination sets `resHi` to zero.
- R7: `doneOut` is high exactly two clock edges after an edge that samples `startIn` high, and is low otherwise. A new operation may be issued in every cycle.
- R8: Bits 31:24 of `opA` and `opB` have no effect on any result.
- R9: If `accReq` is high with code 2 or 3, the result goes to `accOut`. In that case `dstWrite` stays low and `resLo`/`resHi` keep their values. For every other operation, `accReq` has no effect: `dstWrite` rises with `doneOut` and `accOut` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Issue strobe for one operation |
| opSel | input | 3 | Operation code (see R2 to R6) |
| accReq | input | 1 | Send a 22-fraction-bit result to the result register |
| opA | input | 32 | First operand; bits 23:0 are used |
| opB | input | 32 | Second operand; bits 23:0 are used |
| resLo | output | 32 | Destination word (first word of a double-word result) |
| resHi | output | 32 | Second word of a double-word result, else zero |
| accOut | output | 32 | Separate result register |
| doneOut | output | 1 | Result valid strobe |
| dstWrite | output | 1 | Result was written to `resLo`/`resHi` |

## Verification
The bench targets the following corner cases, each chosen because a specific bug would show up there:
- Signed extremes such as -2^23 times -2^23, and -1 times -1. A missing sign extension or a wrong multiplier width would give large wrong values here.
- Fixed-point cases where -1.0 times 1.0 must come out as an exact negative word. A logical shift in place of an arithmetic one would fill the top bits with zeros.
- Double-word results whose upper half holds the sign. Swapped words, or a zero-filled high half, would show up here.
- Operands with garbage in bits 31:24, which catch a datapath that lets those bits in.
- The accumulator flag given with each kind of operation, which exposes a unit that writes both destinations or ignores the flag.
- Back-to-back operations with idle gaps between them, which catch a misplaced done strobe or results arriving in the wrong cycle.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

  typedef enum logic [2:0] {
    OP_MULU  = 3'd0,
    OP_MULS  = 3'd1,
    OP_SCLS  = 3'd2,
    OP_SCLU  = 3'd3,
    OP_WIDEU = 3'd4,
    OP_WIDES = 3'd5,
    OP_FXS   = 3'd6,
    OP_FXU   = 3'd7
  } opCodeE;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_FX   = 2'd1,
    SH_FRAC = 2'd2
  } shiftE;

  typedef struct packed {
    logic  fire;
    logic  signedOp;
    shiftE shift;
    logic  wide;
    logic  toAcc;
  } ctrlStrobeS;

endpackage

// File: rtl/fxmul_ctrl.sv
module fxmul_ctrl
  import fxmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startIn,
  input  logic [2:0] opIn,
  input  logic       accReqIn,
  output ctrlStrobeS strobe,
  output logic       doneOut,
  output logic       dstWriteOut
);

  logic   validS1;
  opCodeE opS1;
  logic   accS1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validS1 <= 1'b0;
      opS1    <= OP_MULU;
      accS1   <= 1'b0;
    end else begin
      validS1 <= startIn;
      if (startIn) begin
        opS1  <= opCodeE'(opIn);
        accS1 <= accReqIn;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.fire     = validS1;
    strobe.shift    = SH_NONE;
    case (opS1)
      OP_MULU:  strobe.signedOp = 1'b0;
      OP_MULS:  strobe.signedOp = 1'b1;
      OP_SCLS: begin
        strobe.signedOp = 1'b1;
        strobe.shift    = SH_FRAC;
      end
      OP_SCLU: begin
        strobe.signedOp = 1'b0;
        strobe.shift    = SH_FRAC;
      end
      OP_WIDEU: strobe.wide = 1'b1;
      OP_WIDES: begin
        strobe.signedOp = 1'b1;
        strobe.wide     = 1'b1;
      end
      OP_FXS: begin
        strobe.signedOp = 1'b1;
        strobe.shift    = SH_FX;
      end
      OP_FXU:   strobe.shift = SH_FX;
      default:  strobe.signedOp = 1'b0;
    endcase
    strobe.toAcc = accS1 && (opS1 == OP_SCLS || opS1 == OP_SCLU);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneOut     <= 1'b0;
      dstWriteOut <= 1'b0;
    end else begin
      doneOut     <= validS1;
      dstWriteOut <= validS1 && !strobe.toAcc;
    end
  end

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startIn |-> ##2 doneOut);

  // R7
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !startIn |-> ##2 !doneOut);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!doneOut && !dstWriteOut));

  // R9
  acc_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.toAcc) |=> (doneOut && !dstWriteOut));

endmodule

// File: rtl/fxmul_dpath.sv
module fxmul_dpath
  import fxmul_pkg::*;
#(
  parameter int OPW     = 24,
  parameter int WORD    = 32,
  parameter int FX_SH   = 16,
  parameter int FRAC_SH = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            startIn,
  input  logic [WORD-1:0] opA,
  input  logic [WORD-1:0] opB,
  input  ctrlStrobeS      strobe,
  output logic [WORD-1:0] resLo,
  output logic [WORD-1:0] resHi,
  output logic [WORD-1:0] accOut
);

  localparam int PW   = 2 * OPW;
  localparam int MW   = 2 * OPW + 2;
  localparam int EXTW = 2 * WORD;
  localparam int SGNB = PW - FRAC_SH - 1;

  logic [OPW-1:0] aReg, bReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aReg <= '0;
      bReg <= '0;
    end else if (startIn) begin
      aReg <= opA[OPW-1:0];
      bReg <= opB[OPW-1:0];
    end
  end

  logic                   signA, signB;
  logic signed [MW-1:0]   aX, bX, prodFull;
  logic [EXTW-1:0]        prodExt;
  logic signed [EXTW-1:0] shifted;
  logic [WORD-1:0]        nextLo, nextHi;
  logic                   unusedBits;

  always_comb begin
    signA    = strobe.signedOp & aReg[OPW-1];
    signB    = strobe.signedOp & bReg[OPW-1];
    aX       = $signed({{(OPW+2){signA}}, aReg});
    bX       = $signed({{(OPW+2){signB}}, bReg});
    prodFull = aX * bX;
    prodExt  = {{(EXTW-PW){strobe.signedOp & prodFull[PW-1]}}, prodFull[PW-1:0]};
    case (strobe.shift)
      SH_FX:   shifted = $signed(prodExt) >>> FX_SH;
      SH_FRAC: shifted = $signed(prodExt) >>> FRAC_SH;
      default: shifted = $signed(prodExt);
    endcase
    nextLo = shifted[WORD-1:0];
    nextHi = strobe.wide ? prodExt[EXTW-1:WORD] : '0;
  end

  assign unusedBits = ^{opA[WORD-1:OPW], opB[WORD-1:OPW],
                        prodFull[MW-1:PW], shifted[EXTW-1:WORD]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resLo  <= '0;
      resHi  <= '0;
      accOut <= '0;
    end else if (strobe.fire) begin
      if (strobe.toAcc) begin
        accOut <= nextLo;
      end else begin
        resLo <= nextLo;
        resHi <= nextHi;
      end
    end
  end

  // R6
  nonwide_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && !strobe.wide && !strobe.toAcc) |=> (resHi == '0));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.fire && strobe.toAcc) |=> $stable(accOut));

  // R9
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.toAcc) |=> ($stable(resLo) && $stable(resHi)));

  // R4
  frac_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && !strobe.toAcc && strobe.signedOp && strobe.shift == SH_FRAC)
      |=> ((&resLo[WORD-1:SGNB]) || !(|resLo[WORD-1:SGNB])));

endmodule

// File: rtl/fxmul_unit.sv
module fxmul_unit
  import fxmul_pkg::*;
#(
  parameter int OPW     = 24,
  parameter int WORD    = 32,
  parameter int FX_SH   = 16,
  parameter int FRAC_SH = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            startIn,
  input  logic [2:0]      opSel,
  input  logic            accReq,
  input  logic [WORD-1:0] opA,
  input  logic [WORD-1:0] opB,
  output logic [WORD-1:0] resLo,
  output logic [WORD-1:0] resHi,
  output logic [WORD-1:0] accOut,
  output logic            doneOut,
  output logic            dstWrite
);

  ctrlStrobeS strobe;

  fxmul_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .startIn     (startIn),
    .opIn        (opSel),
    .accReqIn    (accReq),
    .strobe      (strobe),
    .doneOut     (doneOut),
    .dstWriteOut (dstWrite)
  );

  fxmul_dpath #(
    .OPW     (OPW),
    .WORD    (WORD),
    .FX_SH   (FX_SH),
    .FRAC_SH (FRAC_SH)
  ) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .startIn (startIn),
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .resLo   (resLo),
    .resHi   (resHi),
    .accOut  (accOut)
  );

endmodule

// File: tb/fxmul_unit_test.sv
`timescale 1ns/1ps
module fxmul_unit_test;

  localparam int N = 600;
  localparam int ND = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startIn = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic        accReq = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] resLo, resHi, accOut;
  logic        doneOut, dstWrite;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fxmul_unit uut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .opSel(opSel), .accReq(accReq),
    .opA(opA), .opB(opB), .resLo(resLo), .resHi(resHi), .accOut(accOut),
    .doneOut(doneOut), .dstWrite(dstWrite)
  );

  logic        vStart [N];
  logic [2:0]  vOp    [N];
  logic        vAcc   [N];
  logic [31:0] vA     [N];
  logic [31:0] vB     [N];

  function automatic longint prodOf(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint pa, pb;
    bit sg;
    sg = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
    pa = sg ? longint'($signed(a[23:0])) : longint'({40'd0, a[23:0]});
    pb = sg ? longint'($signed(b[23:0])) : longint'({40'd0, b[23:0]});
    return pa * pb;
  endfunction

  function automatic logic [31:0] expLo(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint p, s;
    p = prodOf(op, a, b);
    case (op)
      3'd2, 3'd3: s = p >>> 22;
      3'd6, 3'd7: s = p >>> 16;
      default:    s = p;
    endcase
    return s[31:0];
  endfunction

  function automatic logic [31:0] expHi(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    longint p;
    p = prodOf(op, a, b);
    return (op == 3'd4 || op == 3'd5) ? p[63:32] : 32'd0;
  endfunction

  function automatic string reqOf(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd6, 3'd7: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setItem(int i, logic s, logic [2:0] op, logic acc, logic [31:0] a, logic [31:0] b);
    vStart[i] = s; vOp[i] = op; vAcc[i] = acc; vA[i] = a; vB[i] = b;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lastAcc;
    logic [31:0] lastLo, lastHi;
    void'($urandom(32'h5eed_1234));

    // directed corners
    setItem(0,  1, 3'd1, 0, 32'h00FF_FFFF, 32'h00FF_FFFF); // R3 -1*-1
    setItem(1,  1, 3'd1, 0, 32'h0080_0000, 32'h0080_0000); // R3 min*min
    setItem(2,  1, 3'd0, 0, 32'h0000_FFFF, 32'h0000_FFFF); // R2 16x16
    setItem(3,  1, 3'd5, 0, 32'h0080_0000, 32'h007F_FFFF); // R6 signed wide
    setItem(4,  1, 3'd4, 0, 32'h00FF_FFFF, 32'h00FF_FFFF); // R6 unsigned wide
    setItem(5,  1, 3'd2, 0, 32'h0040_0000, 32'h00C0_0000); // R4 1.0*-1.0
    setItem(6,  1, 3'd6, 0, 32'h0001_0000, 32'h00FF_0000); // R5 1.0*-1.0
    setItem(7,  0, 3'd0, 0, 32'h0, 32'h0);                 // R7 idle gap
    setItem(8,  1, 3'd2, 1, 32'h0080_0000, 32'h0040_0000); // R9 to acc
    setItem(9,  1, 3'd1, 1, 32'h0000_0007, 32'h00FF_FFFD); // R9 flag ignored
    setItem(10, 1, 3'd0, 0, 32'hAB00_0003, 32'hCD00_0005); // R8 garbage
    setItem(11, 1, 3'd3, 1, 32'hFFFF_FFFF, 32'h00FF_FFFF); // R9 unsigned acc
    for (int i = ND; i < N; i++) begin
      setItem(i, ($urandom % 8) != 0, 3'($urandom % 8), ($urandom % 4) == 0,
              $urandom, $urandom);
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "done in reset", {63'd0, doneOut}, 64'd0);
    check("R1", "dstWrite in reset", {63'd0, dstWrite}, 64'd0);
    check("R1", "results in reset", {resLo, resHi}, 64'd0);
    check("R1", "acc in reset", {32'd0, accOut}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", {63'd0, doneOut}, 64'd0);
    check("R1", "results after reset", {resLo ^ accOut, resHi}, 64'd0);

    lastAcc = '0; lastLo = '0; lastHi = '0;
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 2) begin
        int k;
        k = i - 2;
        if (!vStart[k]) begin
          check("R7", "done with no issue", {63'd0, doneOut}, 64'd0);
        end else begin
          logic [31:0] eLo, eHi;
          bit toAcc;
          string rq;
          eLo = expLo(vOp[k], vA[k], vB[k]);
          eHi = expHi(vOp[k], vA[k], vB[k]);
          toAcc = vAcc[k] && (vOp[k] == 3'd2 || vOp[k] == 3'd3);
          rq = (k == 10) ? "R8" : reqOf(vOp[k]);
          check("R7", "done two cycles after issue", {63'd0, doneOut}, 64'd1);
          if (toAcc) begin
            check("R9", "dstWrite for acc op", {63'd0, dstWrite}, 64'd0);
            check("R9", "acc value", {32'd0, accOut}, {32'd0, eLo});
            check("R9", "dest held", {resLo, resHi}, {lastLo, lastHi});
            lastAcc = eLo;
          end else begin
            check("R9", "dstWrite for dest op", {63'd0, dstWrite}, 64'd1);
            check(rq, "result words", {resHi, resLo}, {eHi, eLo});
            check("R9", "acc unchanged", {32'd0, accOut}, {32'd0, lastAcc});
            lastLo = eLo; lastHi = eHi;
          end
        end
      end
      if (i < N) begin
        startIn = vStart[i]; opSel = vOp[i]; accReq = vAcc[i];
        opA = vA[i]; opB = vB[i];
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule